// File: doc/BRIEF.md
# Sequenced Hardware Breakpoint Unit

This debug block watches a bus-monitor interface and raises a break interrupt request when programmed access conditions are seen. It has four channels, A to D. Each channel compares the access address (with a per-bit ignore mask), the transfer direction, the bus master, the cycle kind and the operand size against its own settings. Channels C and D can also compare the data value under a mask, and they can require a programmed number of matches before they fire.

Channels fire on their own, or they can be chained so that a break is raised only when the last channel of the chain matches after the earlier ones have matched in order. Three chain lengths are available: C then D, B then C then D, and A then B then C then D. Channels that come before the chosen chain keep firing on their own. A pending break holds until software acknowledges it. The acknowledge also restarts the sequence and the match counters. For fetch cycles, a per-channel bit tells the core whether to stop before or after the instruction executes. Separately, a four-pair circular buffer records the source and target addresses of taken branches. All settings are reached through a simple register write/read port.

Top module: `bkpt_unit`

## Requirements
- R1: In independent mode (control bits [1:0] = 00), a valid bus cycle that matches an enabled channel (condition bit 8 set) sets `breakReq` one clock later, with `breakChan` bit i set for the firing channel (bit 0 = A, 1 = B, 2 = C, 3 = D).
- R2: Address compare: a channel matches only if `busAddr` equals its address register in every bit whose address-mask bit is 0; bits whose mask bit is 1 are ignored.
- R3: Condition fields, where 00 means "any": bits [1:0] direction (01 read, 10 write); bits [3:2] master (01 CPU, 10 DMA); bits [5:4] cycle (01 fetch, 10 data); bits [7:6] size (01 byte, 10 word, 11 longword, matching `busSize` 0, 1, 2).
- R4: Channels C and D with condition bit 10 set also require `busData` to equal their data register in every bit whose data-mask bit is 0.
- R5: Channels C and D fire on the Nth counted match, where N is condition bits [22:11] (0 counts as 1). The counter restarts after each firing.
- R6: Control bits [1:0] select 01 = C→D, 10 = B→C→D, 11 = A→B→C→D. A chain advances by one channel per matching cycle, only on the channel it is waiting for, and it fires only when D matches as the last step. Channels ahead of the chain stay independent.
- R7: `breakReq`, `breakChan` and `breakAfter` hold while a break is pending, and later matches are ignored. `irqAck` clears them and restarts the sequence and counters. A write to the control register (address 16) also restarts the sequence and counters.
- R8: `breakAfter` is set with a break exactly when the triggering cycle was a fetch and a firing channel has condition bit 9 set.
- R9: Each `brValid` cycle stores (`brSrc`, `brDst`) in slot `next`, and the store wraps around and overwrites the oldest pair. Slot k is read with its source at address 24+2k and its destination at 25+2k. The status register at address 17 reads [1:0] = next slot and [4:2] = valid pairs, which saturates at 4.
- R10: After reset there is no pending break, every register reads 0 and all channels are disabled. Register addresses: 0–3 channel address, 4–7 address mask, 8–11 condition, 12/13 data C/D, 14/15 data mask C/D, 16 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | A bus cycle is present this clock |
| busAddr | input | AW | Bus cycle address |
| busData | input | DW | Bus cycle data |
| busWrite | input | 1 | 1 = write, 0 = read |
| busDma | input | 1 | 1 = DMA master, 0 = CPU |
| busFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| busSize | input | 2 | Operand size: 0 byte, 1 word, 2 longword |
| brValid | input | 1 | A branch pair is present this clock |
| brSrc | input | AW | Branch source address |
| brDst | input | AW | Branch target address |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| irqAck | input | 1 | Break acknowledge |
| breakReq | output | 1 | Break interrupt request |
| breakChan | output | 4 | Channels that caused the break |
| breakAfter | output | 1 | Stop after (1) or before (0) the fetched instruction |

## Verification
The assertions assume that `irqAck` is pulsed only for acknowledges. They also assume that a bus cycle always presents a stable, defined set of attribute bits for the cycle in which `busValid` is high. The bench drives every bus, branch and register input for exactly one clock, from a falling edge, and returns the strobes to 0 afterwards. It never raises `irqAck` together with a bus cycle, so the "ignored while clearing" case does not occur. Configuration writes are made only between bus cycles, which keeps each expected break tied to a single observed access.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NCH  = 4;
  localparam int RAW  = 5;
  localparam int REGW = 32;

  localparam logic [RAW-1:0] R_AMASK = 5'd4;
  localparam logic [RAW-1:0] R_COND  = 5'd8;
  localparam logic [RAW-1:0] R_DATA  = 5'd12;
  localparam logic [RAW-1:0] R_DMASK = 5'd14;
  localparam logic [RAW-1:0] R_CTRL  = 5'd16;
  localparam logic [RAW-1:0] R_TSTAT = 5'd17;
  localparam logic [RAW-1:0] R_TRACE = 5'd24;

  localparam int C_EN    = 8;
  localparam int C_AFTER = 9;
  localparam int C_DATA  = 10;
  localparam int C_CNT   = 11;

  typedef struct packed {
    logic [NCH-1:0] eligible;
    logic           clrCnt;
  } ctrlStrobe_t;
endpackage

// File: rtl/bkpt_dp.sv
module bkpt_dp
  import bkpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CNTW = 12,
  parameter int TPAIRS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic [AW-1:0]      busAddr,
  input  logic [DW-1:0]      busData,
  input  logic               busWrite,
  input  logic               busDma,
  input  logic               busFetch,
  input  logic [1:0]         busSize,
  input  logic               brValid,
  input  logic [AW-1:0]      brSrc,
  input  logic [AW-1:0]      brDst,
  input  logic               regWe,
  input  logic [RAW-1:0]     regAddr,
  input  logic [REGW-1:0]    regWdata,
  output logic [REGW-1:0]    regRdata,
  input  ctrlStrobe_t        strobe,
  output logic [NCH-1:0]     chHit,
  output logic [NCH-1:0]     chAfter,
  output logic [1:0]         seqMode,
  output logic               ctrlWrite
);
  localparam int TPW = $clog2(TPAIRS);

  logic [AW-1:0]   addrVal  [NCH];
  logic [AW-1:0]   addrMask [NCH];
  logic [REGW-1:0] cond     [NCH];
  logic [DW-1:0]   dataVal  [2];
  logic [DW-1:0]   dataMask [2];
  logic [1:0]      ctrlReg;
  logic [AW-1:0]   trSrc [TPAIRS];
  logic [AW-1:0]   trDst [TPAIRS];
  logic [TPW-1:0]  trPtr;
  logic [TPW:0]    trCnt;
  logic [TPW-1:0]  trIdx;

  assign seqMode   = ctrlReg;
  assign ctrlWrite = regWe && (regAddr == R_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        addrVal[i] <= '0; addrMask[i] <= '0; cond[i] <= '0;
      end
      for (int i = 0; i < 2; i++) begin
        dataVal[i] <= '0; dataMask[i] <= '0;
      end
      ctrlReg <= '0;
    end else if (regWe) begin
      if (regAddr < R_AMASK)       addrVal[regAddr[1:0]]  <= AW'(regWdata);
      else if (regAddr < R_COND)   addrMask[regAddr[1:0]] <= AW'(regWdata);
      else if (regAddr < R_DATA)   cond[regAddr[1:0]]     <= regWdata;
      else if (regAddr < R_DMASK)  dataVal[regAddr[0]]    <= DW'(regWdata);
      else if (regAddr < R_CTRL)   dataMask[regAddr[0]]   <= DW'(regWdata);
      else if (regAddr == R_CTRL)  ctrlReg                <= regWdata[1:0];
    end
  end

  // per-channel comparators; C and D add data compare and a match counter
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [1:0] fDir, fMst, fCyc, fSz;
    logic addrOk, attrOk, dataOk, match, reached;
    assign fDir = cond[i][1:0];
    assign fMst = cond[i][3:2];
    assign fCyc = cond[i][5:4];
    assign fSz  = cond[i][7:6];
    assign addrOk = ((busAddr ^ addrVal[i]) & ~addrMask[i]) == '0;
    assign attrOk = (fDir == 2'b00 || fDir == {busWrite, ~busWrite})
                 && (fMst == 2'b00 || fMst == {busDma, ~busDma})
                 && (fCyc == 2'b00 || fCyc == {~busFetch, busFetch})
                 && (fSz  == 2'b00 || fSz  == 2'(busSize + 2'd1));
    assign match = busValid && cond[i][C_EN] && addrOk && attrOk && dataOk;
    assign chHit[i]   = match && strobe.eligible[i] && reached;
    assign chAfter[i] = cond[i][C_AFTER];

    if (i >= 2) begin : g_cnt
      logic [CNTW-1:0] cnt;
      logic [CNTW-1:0] limit;
      assign limit   = cond[i][C_CNT +: CNTW];
      assign dataOk  = !cond[i][C_DATA] ||
                       ((busData ^ dataVal[i-2]) & ~dataMask[i-2]) == '0;
      assign reached = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
      always_ff @(posedge clk) begin
        if (!rstN || strobe.clrCnt)                cnt <= '0;
        else if (match && strobe.eligible[i])      cnt <= reached ? '0 : cnt + 1'b1;
      end
    end else begin : g_plain
      assign dataOk  = 1'b1;
      assign reached = 1'b1;
    end
  end

  // branch trace ring
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trPtr <= '0;
      trCnt <= '0;
      for (int k = 0; k < TPAIRS; k++) begin
        trSrc[k] <= '0; trDst[k] <= '0;
      end
    end else if (brValid) begin
      trSrc[trPtr] <= brSrc;
      trDst[trPtr] <= brDst;
      trPtr <= trPtr + 1'b1;
      if (trCnt != (TPW+1)'(TPAIRS)) trCnt <= trCnt + 1'b1;
    end
  end

  assign trIdx = TPW'((regAddr - R_TRACE) >> 1);

  always_comb begin
    regRdata = '0;
    if (regAddr < R_AMASK)       regRdata = REGW'(addrVal[regAddr[1:0]]);
    else if (regAddr < R_COND)   regRdata = REGW'(addrMask[regAddr[1:0]]);
    else if (regAddr < R_DATA)   regRdata = cond[regAddr[1:0]];
    else if (regAddr < R_DMASK)  regRdata = REGW'(dataVal[regAddr[0]]);
    else if (regAddr < R_CTRL)   regRdata = REGW'(dataMask[regAddr[0]]);
    else if (regAddr == R_CTRL)  regRdata = REGW'(ctrlReg);
    else if (regAddr == R_TSTAT) regRdata = REGW'({trCnt, trPtr});
    else if (regAddr >= R_TRACE) regRdata = regAddr[0] ? REGW'(trDst[trIdx]) : REGW'(trSrc[trIdx]);
  end
endmodule

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] chHit,
  input  logic [NCH-1:0] chAfter,
  input  logic [1:0]     seqMode,
  input  logic           ctrlWrite,
  input  logic           irqAck,
  input  logic           busFetch,
  output ctrlStrobe_t    strobe,
  output logic           breakReq,
  output logic [NCH-1:0] breakChan,
  output logic           breakAfter
);
  logic [2:0]     chainStart;
  logic [1:0]     stageOff;
  logic [2:0]     stage;
  logic           clearSeq, inChain, lastHit, advance;
  logic [NCH-1:0] fireVec;

  always_comb begin
    case (seqMode)
      2'b11:   chainStart = 3'd0;
      2'b10:   chainStart = 3'd1;
      2'b01:   chainStart = 3'd2;
      default: chainStart = 3'd4;
    endcase
  end

  assign inChain  = chainStart != 3'd4;
  assign stage    = chainStart + {1'b0, stageOff};
  assign clearSeq = irqAck || ctrlWrite;

  always_comb begin
    for (int i = 0; i < NCH; i++)
      strobe.eligible[i] = !breakReq && !clearSeq &&
                           (3'(i) < chainStart || 3'(i) == stage);
    strobe.clrCnt = clearSeq;
  end

  assign lastHit = inChain && stage == 3'd3 && chHit[3];
  assign advance = inChain && stage < 3'd3 && chHit[stage[1:0]];

  always_comb begin
    for (int i = 0; i < NCH; i++)
      fireVec[i] = chHit[i] && 3'(i) < chainStart;
    if (lastHit) fireVec[3] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearSeq)  stageOff <= '0;
    else if (lastHit)       stageOff <= '0;
    else if (advance)       stageOff <= stageOff + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || irqAck) begin
      breakReq   <= 1'b0;
      breakChan  <= '0;
      breakAfter <= 1'b0;
    end else if (!breakReq && fireVec != '0) begin
      breakReq   <= 1'b1;
      breakChan  <= fireVec;
      breakAfter <= busFetch && ((fireVec & chAfter) != '0);
    end
  end
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CNTW = 12,
  parameter int TPAIRS = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busValid,
  input  logic [AW-1:0]   busAddr,
  input  logic [DW-1:0]   busData,
  input  logic            busWrite,
  input  logic            busDma,
  input  logic            busFetch,
  input  logic [1:0]      busSize,
  input  logic            brValid,
  input  logic [AW-1:0]   brSrc,
  input  logic [AW-1:0]   brDst,
  input  logic            regWe,
  input  logic [4:0]      regAddr,
  input  logic [31:0]     regWdata,
  output logic [31:0]     regRdata,
  input  logic            irqAck,
  output logic            breakReq,
  output logic [3:0]      breakChan,
  output logic            breakAfter
);
  ctrlStrobe_t    strobe;
  logic [NCH-1:0] chHit, chAfter;
  logic [1:0]     seqMode;
  logic           ctrlWrite;

  bkpt_dp #(.AW(AW), .DW(DW), .CNTW(CNTW), .TPAIRS(TPAIRS)) uDp (
    .clk, .rstN, .busValid, .busAddr, .busData, .busWrite, .busDma,
    .busFetch, .busSize, .brValid, .brSrc, .brDst, .regWe, .regAddr,
    .regWdata, .regRdata, .strobe, .chHit, .chAfter, .seqMode, .ctrlWrite
  );

  bkpt_ctrl uCtrl (
    .clk, .rstN, .chHit, .chAfter, .seqMode, .ctrlWrite, .irqAck,
    .busFetch, .strobe, .breakReq, .breakChan, .breakAfter
  );
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          busValid,
  input logic [AW-1:0] busAddr,
  input logic [DW-1:0] busData,
  input logic          busWrite,
  input logic          busDma,
  input logic          busFetch,
  input logic [1:0]    busSize,
  input logic          brValid,
  input logic [AW-1:0] brSrc,
  input logic [AW-1:0] brDst,
  input logic          regWe,
  input logic [4:0]    regAddr,
  input logic [31:0]   regWdata,
  input logic [31:0]   regRdata,
  input logic          irqAck,
  input logic          breakReq,
  input logic [3:0]    breakChan,
  input logic          breakAfter
);
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !breakReq && breakChan == 4'd0);

  a_r7_pending_holds: assert property (@(posedge clk) disable iff (!rstN)
    breakReq && !irqAck |=> breakReq && $stable(breakChan) && $stable(breakAfter));

  a_r1_needs_bus_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !busValid && !breakReq |=> !breakReq);

  a_r1_cause_flagged: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> breakChan != 4'd0);

  a_r8_after_only_fetch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakReq) && breakAfter |-> $past(busFetch));

  a_r8_after_with_req: assert property (@(posedge clk) disable iff (!rstN)
    breakAfter |-> breakReq);
endmodule

bind bkpt_unit bkpt_unit_chk #(.AW(AW), .DW(DW)) uChk (.*);

// File: tb/bkpt_unit_test.sv
module bkpt_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 0, busWrite = 0, busDma = 0, busFetch = 0;
  logic [31:0] busAddr = 0, busData = 0;
  logic [1:0]  busSize = 0;
  logic        brValid = 0;
  logic [31:0] brSrc = 0, brDst = 0;
  logic        regWe = 0;
  logic [4:0]  regAddr = 0;
  logic [31:0] regWdata = 0;
  logic [31:0] regRdata;
  logic        irqAck = 0;
  logic        breakReq, breakAfter;
  logic [3:0]  breakChan;

  int nChk = 0, nBad = 0;
  bit done = 0;

  typedef struct { logic req; logic [3:0] ch; logic aft; string tag; } exp_t;
  exp_t q[$];
  exp_t cur;

  bkpt_unit uut (.*);

  always #5 clk = ~clk;

  // monitor: compare queued expectations against outputs at falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      cur = q.pop_front();
      nChk++;
      if (breakReq !== cur.req || breakChan !== cur.ch || breakAfter !== cur.aft) begin
        nBad++;
        $display("FAIL %s: got req=%0b ch=%b aft=%0b expected req=%0b ch=%b aft=%0b",
                 cur.tag, breakReq, breakChan, breakAfter, cur.req, cur.ch, cur.aft);
      end
    end
  end

  task automatic expect_out(input logic r, input logic [3:0] c, input logic a, input string tag);
    exp_t e;
    e.req = r; e.ch = c; e.aft = a; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic bus(input logic [31:0] a, input logic [31:0] d, input logic w,
                     input logic dma, input logic f, input logic [1:0] sz,
                     input logic er, input logic [3:0] ec, input logic ea, input string tag);
    @(negedge clk);
    busValid = 1; busAddr = a; busData = d; busWrite = w;
    busDma = dma; busFetch = f; busSize = sz;
    @(posedge clk); #1;
    busValid = 0;
    expect_out(er, ec, ea, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 0;
  endtask

  task automatic ack(input string tag);
    @(negedge clk);
    irqAck = 1;
    @(posedge clk); #1;
    irqAck = 0;
    expect_out(0, 4'b0000, 0, tag);
  endtask

  task automatic branch(input logic [31:0] s, input logic [31:0] d);
    @(negedge clk);
    brValid = 1; brSrc = s; brDst = d;
    @(posedge clk); #1;
    brValid = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    nChk++;
    if (regRdata !== e) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, regRdata, e);
    end
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R10 reset state
    expect_out(0, 4'b0000, 0, "R10 reset outputs");
    rd(5'd8, 32'h0, "R10 cond A after reset");
    rd(5'd17, 32'h0, "R10 trace status after reset");

    // R1 independent fire on channel A
    wr(5'd0, 32'h1000);
    wr(5'd8, 32'h100);
    bus(32'h1000, 0, 0, 0, 1, 2, 1, 4'b0001, 0, "R1 channel A fires");
    ack("R7 ack clears");

    // R2 address mask
    bus(32'h1004, 0, 0, 0, 1, 2, 0, 4'b0000, 0, "R2 address mismatch");
    wr(5'd4, 32'hF);
    bus(32'h100C, 0, 0, 0, 1, 2, 1, 4'b0001, 0, "R2 masked bits ignored");
    ack("R7 ack");

    // R3 attribute fields
    wr(5'd8, 32'h102);
    bus(32'h1000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R3 read rejected by write filter");
    bus(32'h1000, 0, 1, 0, 0, 2, 1, 4'b0001, 0, "R3 write accepted");
    ack("R7 ack");
    wr(5'd8, 32'h1C0);
    bus(32'h1000, 0, 0, 0, 0, 1, 0, 4'b0000, 0, "R3 word rejected by long filter");
    bus(32'h1000, 0, 0, 0, 0, 2, 1, 4'b0001, 0, "R3 long accepted");
    ack("R7 ack");
    wr(5'd8, 32'h108);
    bus(32'h1000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R3 CPU rejected by DMA filter");
    bus(32'h1000, 0, 0, 1, 0, 2, 1, 4'b0001, 0, "R3 DMA accepted");
    ack("R7 ack");
    wr(5'd8, 32'h120);
    bus(32'h1000, 0, 0, 0, 1, 2, 0, 4'b0000, 0, "R3 fetch rejected by data filter");
    bus(32'h1000, 0, 0, 0, 0, 2, 1, 4'b0001, 0, "R3 data accepted");
    ack("R7 ack");

    // R8 before/after selection
    wr(5'd8, 32'h310);
    bus(32'h1000, 0, 0, 0, 1, 2, 1, 4'b0001, 1, "R8 fetch break after");
    ack("R7 ack");
    wr(5'd8, 32'h300);
    bus(32'h1000, 0, 0, 0, 0, 2, 1, 4'b0001, 0, "R8 data cycle never after");
    ack("R7 ack");
    wr(5'd8, 32'h0);

    // R4 data compare on C
    wr(5'd2, 32'h2000);
    wr(5'd12, 32'hAB);
    wr(5'd10, 32'h500);
    bus(32'h2000, 32'hAC, 1, 0, 0, 2, 0, 4'b0000, 0, "R4 data mismatch");
    bus(32'h2000, 32'hAB, 1, 0, 0, 2, 1, 4'b0100, 0, "R4 data match");
    ack("R7 ack");
    wr(5'd14, 32'hFF);
    bus(32'h2000, 32'hCD, 1, 0, 0, 2, 1, 4'b0100, 0, "R4 data mask");
    ack("R7 ack");
    wr(5'd10, 32'h0);

    // R5 match count on D
    wr(5'd3, 32'h3000);
    wr(5'd11, 32'h1900);
    rd(5'd11, 32'h1900, "R5 count field readback");
    bus(32'h3000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R5 first match counted");
    bus(32'h3000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R5 second match counted");
    bus(32'h3000, 0, 0, 0, 0, 2, 1, 4'b1000, 0, "R5 third match fires");
    ack("R7 ack");
    bus(32'h3000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R5 counter restarted");

    // R6 chain C->D
    wr(5'd10, 32'h100);
    wr(5'd11, 32'h100);
    wr(5'd16, 32'h1);
    bus(32'h3000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R6 D before C ignored");
    bus(32'h2000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R6 C step");
    bus(32'h3000, 0, 0, 0, 0, 2, 1, 4'b1000, 0, "R6 C->D fires");
    ack("R7 ack");
    bus(32'h3000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R7 sequence restarted by ack");

    // R6 chain A->B->C->D
    wr(5'd4, 32'h0);
    wr(5'd8, 32'h100);
    wr(5'd1, 32'h1100);
    wr(5'd9, 32'h100);
    wr(5'd16, 32'h3);
    bus(32'h1000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R6 A step");
    bus(32'h1100, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R6 B step");
    bus(32'h2000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R6 C step");
    bus(32'h3000, 0, 0, 0, 0, 2, 1, 4'b1000, 0, "R6 A->B->C->D fires");
    ack("R7 ack");
    bus(32'h1100, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R6 B out of order");
    bus(32'h1000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R6 A step");
    bus(32'h2000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R6 C skipped B");
    bus(32'h3000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R6 no fire out of order");
    wr(5'd16, 32'h3);
    bus(32'h1000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R6 A step");
    bus(32'h1100, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R6 B step");
    wr(5'd16, 32'h3);
    bus(32'h2000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R7 control write restarted chain");
    bus(32'h3000, 0, 0, 0, 0, 2, 0, 4'b0000, 0, "R7 no fire after restart");

    // R6 B->C->D keeps A independent; R7 pending ignores later matches
    wr(5'd16, 32'h2);
    bus(32'h1000, 0, 0, 0, 0, 2, 1, 4'b0001, 0, "R6 A independent ahead of chain");
    wr(5'd16, 32'h0);
    bus(32'h2000, 0, 0, 0, 0, 2, 1, 4'b0001, 0, "R7 match while pending ignored");
    ack("R7 ack");
    rd(5'd16, 32'h0, "R6 control readback");

    // R9 trace ring
    branch(32'h100, 32'h180);
    branch(32'h200, 32'h280);
    rd(5'd17, 32'd10, "R9 status after two pairs");
    branch(32'h300, 32'h380);
    branch(32'h400, 32'h480);
    branch(32'h500, 32'h580);
    rd(5'd17, 32'd17, "R9 status saturates and wraps");
    rd(5'd24, 32'h500, "R9 oldest slot overwritten src");
    rd(5'd25, 32'h580, "R9 oldest slot overwritten dst");
    rd(5'd26, 32'h200, "R9 slot 1 src");
    rd(5'd31, 32'h480, "R9 slot 3 dst");

    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule